// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs a processor's entry into an exception. It starts when a fault or interrupt request is accepted and ends when it issues the fetch of the handler's first instruction. On acceptance it takes a snapshot of the status register, stack pointer, program counter and vector base. It then builds the new supervisor-mode status value and works out the vector number. For exceptions other than interrupts, the vector comes from the exception kind. For interrupts, it comes from an acknowledge read whose address carries the interrupt level.

Every exception uses the same two-word frame. The frame is pushed onto the single shared stack after the stack pointer has been rounded down to a word boundary, and a format field in the frame records how far it was rounded. The handler address is then read from the vector table. A one-cycle pulse presents that address, together with the new status register and the final stack pointer, to the instruction fetch logic.

Each bus access is a request held until it is acknowledged. A request that arrives while a sequence is in progress is ignored.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `bus_req` and `fetch_valid` are low.
- R2: For every kind, the status value delivered with the handler fetch equals the value sampled at acceptance, with bit 13 (supervisor) set and bit 15 (trace) cleared.
- R3: For an interrupt (kind 7), the delivered status value also has bit 12 (master) cleared, and bits 10:8 (priority mask) are set to the request level.
- R4: Vectors for the other kinds are: kind 0 gives 2, kind 1 gives 3, kind 2 gives 4, kind 3 gives 5, kind 4 gives 8, kind 5 gives 9, and kind 6 gives 32 plus the 4-bit trap number.
- R5: For an interrupt, the first bus access is a read with `bus_iack` high at address 0xFFFFFFE0 + 4*level. Its vector number is `bus_rdata[7:0]`.
- R6: If the acknowledge read completes with `bus_spurious` high, vector 24 is used.
- R7: The first write goes to A-4 with the saved PC, where A is the sampled stack pointer with bits 1:0 cleared. The second write goes to A-8 with the frame word. The frame word holds {2'b01, SP[1:0]} in bits 31:28, the vector in bits 25:18, and the sampled status in bits 15:0. All other bits are zero.
- R8: Kinds 0 to 4 save the faulting PC. Kinds 5 to 7 save the next PC.
- R9: The last access is a read with `bus_iack` low at {VBR[31:20], 10'b0, vector, 2'b00}.
- R10: One cycle after the table read is acknowledged, `fetch_valid` pulses for exactly one cycle. During that pulse, `fetch_addr` equals the read data and `sp_out` equals A-8.
- R11: While `bus_req` is high and `bus_ack` is low, the request, address, data and direction stay unchanged.
- R12: A request arriving while `busy` is high has no effect on the running sequence, and it does not start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request, sampled while idle |
| req_kind | input | 3 | Exception kind (7 = interrupt) |
| req_level | input | 3 | Interrupt level |
| req_trap | input | 4 | Trap number for kind 6 |
| sr_in | input | 16 | Current status register |
| sp_in | input | 32 | Current stack pointer |
| pc_fault | input | 32 | Address of the faulting instruction |
| pc_next | input | 32 | Address of the next instruction |
| vbr_in | input | 32 | Vector base register |
| busy | output | 1 | Sequence in progress |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_iack | output | 1 | Access is in the acknowledge space |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| bus_spurious | input | 1 | Acknowledge read reports a spurious interrupt |
| fetch_valid | output | 1 | One-cycle handler fetch pulse |
| fetch_addr | output | 32 | Handler address |
| sr_out | output | 16 | Updated status register |
| sp_out | output | 32 | Final stack pointer |

## Verification
The assertions take the following for granted about the bus partner:
- `bus_ack` is raised only while `bus_req` is high.
- `bus_rdata` and `bus_spurious` are meaningful only in the acknowledged cycle.
- The request inputs are steady in the cycle where `req_valid` is sampled.

The stimulus responds from a bus model that watches `bus_req` and acknowledges after a random delay. It therefore never acknowledges an idle bus. It raises `bus_spurious` only on the acknowledge read, and it changes request inputs only away from the sampling edge. Stray requests are injected only while a sequence is already running.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int DW     = 32;
    localparam int SRW    = 16;
    localparam int VECW   = 8;
    localparam int SR_T   = 15;
    localparam int SR_S   = 13;
    localparam int SR_M   = 12;
    localparam int MASK_LO = 8;
    localparam int MASK_HI = 10;
    localparam int VBR_KEEP = 12;

    typedef enum logic [2:0] {
        EXC_ACCESS  = 3'd0,
        EXC_ADDRESS = 3'd1,
        EXC_ILLEGAL = 3'd2,
        EXC_ZERODIV = 3'd3,
        EXC_PRIV    = 3'd4,
        EXC_TRACE   = 3'd5,
        EXC_TRAP    = 3'd6,
        EXC_IRQ     = 3'd7
    } exc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IACK,
        ST_PUSH_PC,
        ST_PUSH_FRAME,
        ST_VREAD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [SRW-1:0]      sr_copy;
        logic [SRW-1:0]      sr_new;
        logic [DW-1:0]       sp_align;
        logic [1:0]          skew;
        logic [DW-1:0]       pc_saved;
        logic [VECW-1:0]     vector;
        logic [2:0]          level;
        logic [VBR_KEEP-1:0] vbr_hi;
    } exc_ctx_t;

    function automatic logic [VECW-1:0] kind_vector(exc_kind_e k, logic [3:0] trap,
                                                    logic [VECW-1:0] trap_base);
        logic [VECW-1:0] v;
        case (k)
            EXC_ACCESS:  v = 8'd2;
            EXC_ADDRESS: v = 8'd3;
            EXC_ILLEGAL: v = 8'd4;
            EXC_ZERODIV: v = 8'd5;
            EXC_PRIV:    v = 8'd8;
            EXC_TRACE:   v = 8'd9;
            EXC_TRAP:    v = trap_base + {4'd0, trap};
            default:     v = 8'd0;
        endcase
        return v;
    endfunction

    function automatic logic kind_saves_fault(exc_kind_e k);
        return (k == EXC_ACCESS) || (k == EXC_ADDRESS) || (k == EXC_ILLEGAL) ||
               (k == EXC_ZERODIV) || (k == EXC_PRIV);
    endfunction

    function automatic logic [SRW-1:0] sr_on_entry(logic [SRW-1:0] sr, logic irq,
                                                   logic [2:0] lvl);
        logic [SRW-1:0] r;
        r = sr;
        r[SR_T] = 1'b0;
        r[SR_S] = 1'b1;
        if (irq) begin
            r[SR_M] = 1'b0;
            r[MASK_HI:MASK_LO] = lvl;
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] frame_word(logic [1:0] skew, logic [VECW-1:0] vec,
                                                 logic [SRW-1:0] sr);
        return {2'b01, skew, 2'b00, vec, 2'b00, sr};
    endfunction

    function automatic logic [DW-1:0] table_addr(logic [VBR_KEEP-1:0] vbr_hi,
                                                 logic [VECW-1:0] vec);
        return {vbr_hi, 10'd0, vec, 2'b00};
    endfunction

endpackage

// File: rtl/exc_ctx_capture.sv
module exc_ctx_capture
    import exc_entry_pkg::*;
#(
    parameter logic [VECW-1:0] TRAP_BASE    = 8'd32,
    parameter logic [VECW-1:0] SPURIOUS_VEC = 8'd24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  exc_kind_e       kind,
    input  logic [2:0]      level,
    input  logic [3:0]      trap,
    input  logic [SRW-1:0]  sr,
    input  logic [DW-1:0]   sp,
    input  logic [DW-1:0]   pc_fault,
    input  logic [DW-1:0]   pc_next,
    input  logic [DW-1:0]   vbr,
    input  logic            vec_load,
    input  logic            vec_spurious,
    input  logic [VECW-1:0] vec_data,
    output exc_ctx_t        ctx
);

    logic unused_vbr_low;
    assign unused_vbr_low = ^vbr[DW-VBR_KEEP-1:0];

    logic is_irq;
    assign is_irq = (kind == EXC_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (load) begin
            ctx.sr_copy  <= sr;
            ctx.sr_new   <= sr_on_entry(sr, is_irq, level);
            ctx.sp_align <= {sp[DW-1:2], 2'b00};
            ctx.skew     <= sp[1:0];
            ctx.pc_saved <= kind_saves_fault(kind) ? pc_fault : pc_next;
            ctx.vector   <= is_irq ? '0 : kind_vector(kind, trap, TRAP_BASE);
            ctx.level    <= level;
            ctx.vbr_hi   <= vbr[DW-1:DW-VBR_KEEP];
        end else if (vec_load) begin
            ctx.vector   <= vec_spurious ? SPURIOUS_VEC : vec_data;
        end
    end

    assert_ctx_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!load && !vec_load) |=> $stable(ctx));

    assert_sp_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> (ctx.sp_align[1:0] == 2'b00));

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_irq,
    input  logic       bus_ack,
    output seq_state_e state,
    output logic       accept,
    output logic       vec_load,
    output logic       done_load
);

    seq_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:       if (start) nxt = start_irq ? ST_IACK : ST_PUSH_PC;
            ST_IACK:       if (bus_ack) nxt = ST_PUSH_PC;
            ST_PUSH_PC:    if (bus_ack) nxt = ST_PUSH_FRAME;
            ST_PUSH_FRAME: if (bus_ack) nxt = ST_VREAD;
            ST_VREAD:      if (bus_ack) nxt = ST_DONE;
            ST_DONE:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign accept    = (state == ST_IDLE) && start;
    assign vec_load  = (state == ST_IACK) && bus_ack;
    assign done_load = (state == ST_VREAD) && bus_ack;

    assert_done_follows_read_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |-> ($past(state) == ST_VREAD));

endmodule

// File: rtl/exc_bus_drive.sv
module exc_bus_drive
    import exc_entry_pkg::*;
#(
    parameter logic [DW-6:0] IACK_PREFIX = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_state_e      state,
    input  exc_ctx_t        ctx,
    output logic            bus_req,
    output logic            bus_we,
    output logic            bus_iack,
    output logic [DW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata
);

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_iack  = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (state)
            ST_IACK: begin
                bus_req  = 1'b1;
                bus_iack = 1'b1;
                bus_addr = {IACK_PREFIX, ctx.level, 2'b00};
            end
            ST_PUSH_PC: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ctx.sp_align - DW'(4);
                bus_wdata = ctx.pc_saved;
            end
            ST_PUSH_FRAME: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ctx.sp_align - DW'(8);
                bus_wdata = frame_word(ctx.skew, ctx.vector, ctx.sr_copy);
            end
            ST_VREAD: begin
                bus_req  = 1'b1;
                bus_addr = table_addr(ctx.vbr_hi, ctx.vector);
            end
            default: ;
        endcase
    end

    assert_write_word_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |-> (bus_addr[1:0] == 2'b00));

    assert_iack_is_read_R5: assert property (@(posedge clk) disable iff (rst)
        bus_iack |-> (bus_req && !bus_we));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter logic [7:0]  TRAP_BASE    = 8'd32,
    parameter logic [7:0]  SPURIOUS_VEC = 8'd24,
    parameter logic [26:0] IACK_PREFIX  = '1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_kind,
    input  logic [2:0]  req_level,
    input  logic [3:0]  req_trap,
    input  logic [15:0] sr_in,
    input  logic [31:0] sp_in,
    input  logic [31:0] pc_fault,
    input  logic [31:0] pc_next,
    input  logic [31:0] vbr_in,
    output logic        busy,
    output logic        bus_req,
    output logic        bus_we,
    output logic        bus_iack,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata,
    input  logic        bus_spurious,
    output logic        fetch_valid,
    output logic [31:0] fetch_addr,
    output logic [15:0] sr_out,
    output logic [31:0] sp_out
);

    exc_kind_e  kind;
    seq_state_e state;
    exc_ctx_t   ctx;
    logic       accept, vec_load, done_load;

    assign kind = exc_kind_e'(req_kind);

    exc_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (req_valid),
        .start_irq (kind == EXC_IRQ),
        .bus_ack   (bus_ack),
        .state     (state),
        .accept    (accept),
        .vec_load  (vec_load),
        .done_load (done_load)
    );

    exc_ctx_capture #(
        .TRAP_BASE    (TRAP_BASE),
        .SPURIOUS_VEC (SPURIOUS_VEC)
    ) u_ctx (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .kind         (kind),
        .level        (req_level),
        .trap         (req_trap),
        .sr           (sr_in),
        .sp           (sp_in),
        .pc_fault     (pc_fault),
        .pc_next      (pc_next),
        .vbr          (vbr_in),
        .vec_load     (vec_load),
        .vec_spurious (bus_spurious),
        .vec_data     (bus_rdata[VECW-1:0]),
        .ctx          (ctx)
    );

    exc_bus_drive #(
        .IACK_PREFIX (IACK_PREFIX)
    ) u_bus (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .ctx       (ctx),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_iack  (bus_iack),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_addr <= '0;
            sr_out     <= '0;
            sp_out     <= '0;
        end else if (done_load) begin
            fetch_addr <= bus_rdata;
            sr_out     <= ctx.sr_new;
            sp_out     <= ctx.sp_align - DW'(8);
        end
    end

    assign fetch_valid = (state == ST_DONE);
    assign busy        = (state != ST_IDLE);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_wdata) && $stable(bus_we)));

    assert_fetch_single_R10: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> !fetch_valid);

    assert_sp_out_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (sp_out[1:0] == 2'b00));

    assert_sr_supervisor_R2: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (sr_out[SR_S] && !sr_out[SR_T]));

    assert_no_bus_at_fetch_R10: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> !bus_req);

endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [2:0]  req_level = '0;
    logic [3:0]  req_trap = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] sp_in = '0, pc_fault = '0, pc_next = '0, vbr_in = '0;
    logic        busy, bus_req, bus_we, bus_iack, fetch_valid;
    logic [31:0] bus_addr, bus_wdata, fetch_addr, sp_out;
    logic [15:0] sr_out;
    logic        bus_ack = 1'b0, bus_spurious = 1'b0;
    logic [31:0] bus_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_level(req_level), .req_trap(req_trap), .sr_in(sr_in), .sp_in(sp_in),
        .pc_fault(pc_fault), .pc_next(pc_next), .vbr_in(vbr_in), .busy(busy),
        .bus_req(bus_req), .bus_we(bus_we), .bus_iack(bus_iack), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .bus_spurious(bus_spurious), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .sr_out(sr_out), .sp_out(sp_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_vector(input int kind, input logic [3:0] trap);
        case (kind)
            0: return 8'd2;
            1: return 8'd3;
            2: return 8'd4;
            3: return 8'd5;
            4: return 8'd8;
            5: return 8'd9;
            6: return 8'd32 + {4'd0, trap};
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [15:0] exp_sr(input int kind, input logic [15:0] sr,
                                           input logic [2:0] lvl);
        logic [15:0] r;
        r = sr;
        r[15] = 1'b0;
        r[13] = 1'b1;
        if (kind == 7) begin
            r[12] = 1'b0;
            r[10:8] = lvl;
        end
        return r;
    endfunction

    task automatic run_one(input int kind, input logic [2:0] lvl, input logic [3:0] trap,
                           input logic [15:0] sr, input logic [31:0] sp,
                           input logic [31:0] pcf, input logic [31:0] pcn,
                           input logic [31:0] vbr, input logic [7:0] iackv,
                           input bit spur, input int maxdly, input bit inject);
        logic [31:0] ea[4], ed[4], rsp[4];
        bit ewe[4], eiack[4];
        logic [31:0] aligned, hp, sa, sd;
        logic [7:0] vec;
        bit irq, got, first, swe;
        int ntx, tx, dly, iter, base;
        irq = (kind == 7);
        vec = irq ? (spur ? 8'd24 : iackv) : exp_vector(kind, trap);
        aligned = {sp[31:2], 2'b00};
        hp = 32'h4000_0000 | ({24'd0, vec} << 4) | $urandom_range(0, 15);
        base = 0;
        if (irq) begin
            ea[0] = 32'hFFFF_FFE0 + {27'd0, lvl, 2'b00}; ewe[0] = 0; eiack[0] = 1; ed[0] = '0;
            rsp[0] = spur ? $urandom : {24'd0, iackv};
            base = 1;
        end
        // R7, R8: PC word then frame word
        ea[base] = aligned - 4; ewe[base] = 1; eiack[base] = 0;
        ed[base] = (kind <= 4) ? pcf : pcn; rsp[base] = '0;
        ea[base+1] = aligned - 8; ewe[base+1] = 1; eiack[base+1] = 0;
        ed[base+1] = {2'b01, sp[1:0], 2'b00, vec, 2'b00, sr}; rsp[base+1] = '0;
        // R9: table read
        ea[base+2] = {vbr[31:20], 10'd0, vec, 2'b00}; ewe[base+2] = 0; eiack[base+2] = 0;
        ed[base+2] = '0; rsp[base+2] = hp;
        ntx = base + 3;

        @(negedge clk);
        req_valid = 1; req_kind = kind[2:0]; req_level = lvl; req_trap = trap;
        sr_in = sr; sp_in = sp; pc_fault = pcf; pc_next = pcn; vbr_in = vbr;
        tx = 0; first = 1; dly = 0; iter = 0; got = 0;
        sa = '0; sd = '0; swe = 0;
        while (!got && iter < 300) begin
            @(negedge clk);
            iter++;
            bus_ack = 0; bus_spurious = 0;
            if (iter == 1) req_valid = 0;
            if (inject && iter == 2) begin
                // R12: stray request with other inputs while busy
                req_valid = 1; req_kind = 3'(kind ^ 3); sr_in = ~sr; sp_in = sp + 100;
                pc_fault = ~pcf; pc_next = ~pcn; vbr_in = ~vbr; req_level = ~lvl;
            end
            if (inject && iter == 3) req_valid = 0;
            if (fetch_valid) begin
                got = 1;
                chk(fetch_addr == hp, "R10", "handler address", fetch_addr, hp);
                chk(sp_out == aligned - 8, "R10", "final stack pointer", sp_out, aligned - 8);
                chk(sr_out == exp_sr(kind, sr, lvl), irq ? "R3" : "R2", "status out",
                    {16'd0, sr_out}, {16'd0, exp_sr(kind, sr, lvl)});
            end else if (bus_req) begin
                if (first) begin
                    if (tx >= ntx) begin
                        chk(0, "R12", "extra bus access", bus_addr, 32'h0);
                    end else begin
                        chk(bus_addr == ea[tx], irq && tx == 0 ? "R5" : (tx == ntx-1 ? "R9" : "R7"),
                            "access address", bus_addr, ea[tx]);
                        chk(bus_we == ewe[tx] && bus_iack == eiack[tx], irq && tx == 0 ? "R5" : "R9",
                            "access kind", {30'd0, bus_we, bus_iack}, {30'd0, ewe[tx], eiack[tx]});
                        if (ewe[tx])
                            chk(bus_wdata == ed[tx], tx == base ? "R8" : (spur ? "R6" : "R4"),
                                "write data", bus_wdata, ed[tx]);
                    end
                    sa = bus_addr; sd = bus_wdata; swe = bus_we;
                    dly = $urandom_range(0, maxdly);
                    first = 0;
                end else begin
                    chk(bus_addr == sa && bus_wdata == sd && bus_we == swe, "R11",
                        "held request changed", bus_addr, sa);
                end
                if (dly == 0) begin
                    bus_ack = 1;
                    bus_rdata = (tx < 4) ? rsp[tx] : '0;
                    bus_spurious = (irq && tx == 0 && spur);
                    tx++;
                    first = 1;
                end else begin
                    dly--;
                end
            end
        end
        chk(got, "R10", "handler fetch pulse seen", {31'd0, got}, 32'd1);
        chk(tx == ntx, "R7", "access count", tx, ntx);
        @(negedge clk);
        chk(!fetch_valid && !busy, "R12", "pulse ended, idle again",
            {30'd0, fetch_valid, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !bus_req && !fetch_valid, "R1", "idle after reset",
            {29'd0, busy, bus_req, fetch_valid}, 32'd0);

        // directed corners
        run_one(0, 3'd0, 4'd0, 16'h8000, 32'h0000_1000, 32'h100, 32'h104, 32'h0010_0000, 8'd0, 0, 0, 0);
        run_one(4, 3'd0, 4'd0, 16'hA71F, 32'h0000_2003, 32'h200, 32'h204, 32'h0030_0000, 8'd0, 0, 2, 0);
        run_one(6, 3'd0, 4'd15, 16'h2000, 32'h0000_3001, 32'h300, 32'h302, 32'hFFF8_5432, 8'd0, 0, 1, 0);
        run_one(5, 3'd0, 4'd0, 16'h0000, 32'h0000_0002, 32'h400, 32'h404, 32'h0000_0000, 8'd0, 0, 0, 0);
        run_one(7, 3'd7, 4'd0, 16'h9700, 32'h0000_4000, 32'h500, 32'h504, 32'h1230_0000, 8'd64, 0, 3, 0);
        run_one(7, 3'd2, 4'd0, 16'hF7FF, 32'h0000_5002, 32'h600, 32'h604, 32'h0040_0000, 8'd99, 1, 2, 0);
        run_one(2, 3'd5, 4'd3, 16'h1234, 32'h0000_6001, 32'h700, 32'h702, 32'h0050_0000, 8'd0, 0, 3, 1);
        run_one(7, 3'd4, 4'd0, 16'h3300, 32'h0000_7000, 32'h800, 32'h804, 32'h0060_0000, 8'd200, 0, 2, 1);

        for (int i = 0; i < 120; i++) begin
            int k;
            k = $urandom_range(0, 7);
            run_one(k, 3'($urandom), 4'($urandom), 16'($urandom), $urandom, $urandom, $urandom,
                    $urandom, 8'($urandom), ($urandom_range(0, 3) == 0), $urandom_range(0, 4),
                    ($urandom_range(0, 5) == 0));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule